// File: doc/BRIEF.md
# APB3 Bus Requester

This block turns a simple local command stream into transfers on a single APB3 peripheral bus. A command carries a valid strobe, a write flag, an address and write data. The block takes a command through a ready/accept handshake and runs it through the three bus phases: idle, setup and access. It drives the select, enable, address, direction and write data lines toward one peripheral.

The peripheral stretches the access phase by holding its ready input low for as many cycles as it needs. When ready is seen high, the transfer ends. The block then returns a one-cycle done pulse with the read data and the peripheral's error flag. This works for both reads and writes. If a new command is waiting in the cycle where a transfer ends, the block goes straight into the next setup phase with no idle cycle between the two transfers.

All state changes happen on the rising clock edge. An active-low synchronous reset drops any transfer that is in progress.

Top module: `apb_requester`

## Requirements
- R1: While `rst_n` is low at a rising edge, the following cycle shows `psel`=0, `penable`=0, `rsp_done`=0 and `cmd_ready`=1.
- R2: A command is accepted at a rising edge where `cmd_valid` and `cmd_ready` are both 1. The next cycle is the setup phase, with `psel`=1 and `penable`=0. In that phase `paddr`, `pwrite` and `pwdata` carry the accepted command's fields.
- R3: The setup phase lasts exactly one cycle and is always followed by an access phase (`psel`=1, `penable`=1).
- R4: `penable` is 1 only while `psel` is 1.
- R5: Each cycle in access with `pready`=0 adds one wait cycle. Through setup and all wait cycles, `paddr`, `pwrite`, `pwdata` and `psel` do not change. A peripheral that asks for N wait cycles sees an access phase of N+1 cycles.
- R6: `cmd_ready` is 1 only in idle, or in an access cycle where `pready`=1. A command offered during setup or during a wait cycle is not taken, and the bus does not change because of it.
- R7: In the cycle after an access cycle with `pready`=1, `rsp_done` is 1 for exactly one cycle. `rsp_error` equals the `pslverr` sampled in that access cycle, for reads and for writes. `rsp_rdata` equals the sampled `prdata` for a read and is zero for a write.
- R8: If a command is accepted in the completing access cycle, the next cycle is setup (`psel`=1, `penable`=0) with no idle cycle between the two transfers.
- R9: If no command is accepted in the completing access cycle, the next cycle is idle (`psel`=0).
- R10: A reset during an access phase ends the transfer. No `rsp_done` pulse is produced for it, and the block takes new commands afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The block takes the offered command at this edge |
| cmd_write | input | 1 | 1 for a write, 0 for a read |
| cmd_addr | input | ADDR_W (16) | Command address |
| cmd_wdata | input | DATA_W (32) | Command write data |
| rsp_done | output | 1 | One-cycle pulse: a transfer has finished |
| rsp_rdata | output | DATA_W (32) | Read data of the finished transfer (zero for writes) |
| rsp_error | output | 1 | Peripheral error flag of the finished transfer |
| psel | output | 1 | Peripheral select |
| penable | output | 1 | Access phase strobe |
| paddr | output | ADDR_W (16) | Bus address |
| pwrite | output | 1 | Bus direction, 1 for a write |
| pwdata | output | DATA_W (32) | Bus write data |
| pready | input | 1 | Peripheral ready, low inserts a wait cycle |
| prdata | input | DATA_W (32) | Peripheral read data |
| pslverr | input | 1 | Peripheral error response |

## Verification
The bench uses a peripheral model whose behaviour is set by the address it sees:
- The low two address bits set the number of wait cycles, from zero to three.
- An address ending in hex F returns an error.

The main function is tried with four patterns, and each one separates different faults:
- Isolated commands with idle gaps show whether the block falls back to idle.
- Back-to-back bursts show whether it chains directly into setup. They also show whether a command offered during setup or a wait cycle is wrongly taken early.
- Error-tagged reads and writes show whether the error flag is carried for both directions, and whether read data is kept apart from write completions.
- A reset in the middle of a stretched access checks that the abandoned transfer leaves no response behind.

// File: rtl/apb_req_pkg.sv
package apb_req_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2
    } phase_e;

endpackage

// File: rtl/apb_req_fsm.sv
module apb_req_fsm
    import apb_req_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic pready,
    output logic cmd_ready,
    output logic accept,
    output logic complete,
    output logic psel,
    output logic penable
);

    typedef struct packed {
        phase_e phase;
    } fsm_t;

    fsm_t fsm_q, fsm_d;

    always_comb begin
        fsm_d     = fsm_q;
        complete  = (fsm_q.phase == PH_ACCESS) && pready;
        cmd_ready = (fsm_q.phase == PH_IDLE) || complete;
        accept    = cmd_valid && cmd_ready;
        case (fsm_q.phase)
            PH_IDLE:   if (accept) fsm_d.phase = PH_SETUP;
            PH_SETUP:  fsm_d.phase = PH_ACCESS;
            PH_ACCESS: begin
                if (complete) fsm_d.phase = accept ? PH_SETUP : PH_IDLE;
            end
            default:   fsm_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fsm_q <= '{phase: PH_IDLE};
        else        fsm_q <= fsm_d;
    end

    assign psel    = (fsm_q.phase != PH_IDLE);
    assign penable = (fsm_q.phase == PH_ACCESS);

    // Setup always lasts one cycle and leads into access.
    assert_setup_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !penable) |=> (psel && penable));

    // The enable strobe never appears without the select line.
    assert_enable_with_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        penable |-> psel);

    // The first bus cycle of a transfer is a setup cycle.
    assert_enters_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(psel) |-> !penable);

    // A command taken in the completing cycle chains straight into setup.
    assert_chain_to_setup_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pready && cmd_valid) |=> (psel && !penable));

    // No command is taken during setup or a wait cycle.
    assert_ready_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !(psel && !penable) && !(penable && !pready));

endmodule

// File: rtl/apb_req_hold.sv
module apb_req_hold #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              pwrite,
    output logic [ADDR_W-1:0] paddr,
    output logic [DATA_W-1:0] pwdata
);

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } hold_t;

    hold_t hold_q, hold_d;

    always_comb begin
        hold_d = hold_q;
        if (load) begin
            hold_d.write = cmd_write;
            hold_d.addr  = cmd_addr;
            hold_d.wdata = cmd_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign pwrite = hold_q.write;
    assign paddr  = hold_q.addr;
    assign pwdata = hold_q.wdata;

endmodule

// File: rtl/apb_req_resp.sv
module apb_req_resp #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              complete,
    input  logic              pwrite,
    input  logic [DATA_W-1:0] prdata,
    input  logic              pslverr,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_error
);

    typedef struct packed {
        logic              done;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } resp_t;

    resp_t resp_q, resp_d;

    always_comb begin
        resp_d      = resp_q;
        resp_d.done = complete;
        if (complete) begin
            resp_d.rdata = pwrite ? '0 : prdata;
            resp_d.err   = pslverr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign rsp_done  = resp_q.done;
    assign rsp_rdata = resp_q.rdata;
    assign rsp_error = resp_q.err;

    // A done pulse never lasts two cycles: a transfer takes at least setup plus access.
    assert_done_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

endmodule

// File: rtl/apb_requester.sv
module apb_requester #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_error,
    output logic              psel,
    output logic              penable,
    output logic [ADDR_W-1:0] paddr,
    output logic              pwrite,
    output logic [DATA_W-1:0] pwdata,
    input  logic              pready,
    input  logic [DATA_W-1:0] prdata,
    input  logic              pslverr
);

    logic accept;
    logic complete;

    apb_req_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .pready    (pready),
        .cmd_ready (cmd_ready),
        .accept    (accept),
        .complete  (complete),
        .psel      (psel),
        .penable   (penable)
    );

    apb_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .cmd_write (cmd_write),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata)
    );

    apb_req_resp #(.DATA_W(DATA_W)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .complete  (complete),
        .pwrite    (pwrite),
        .prdata    (prdata),
        .pslverr   (pslverr),
        .rsp_done  (rsp_done),
        .rsp_rdata (rsp_rdata),
        .rsp_error (rsp_error)
    );

    // Bus fields stay put from setup into access.
    assert_setup_fields_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !penable) |=> ($stable(paddr) && $stable(pwrite) && $stable(pwdata)));

    // A wait cycle keeps the bus frozen.
    assert_wait_holds_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pready) |=>
            (psel && penable && $stable(paddr) && $stable(pwrite) && $stable(pwdata)));

    // Completion with nothing offered drops back to idle.
    assert_return_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pready && !cmd_valid) |=> !psel);

    // A done pulse follows a completing access cycle.
    assert_done_after_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(psel && penable && pready));

endmodule

// File: tb/apb_requester_test.sv
`timescale 1ns/1ps
module apb_requester_test;

    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic          cmd_write = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_error;
    logic          psel, penable, pwrite;
    logic [AW-1:0] paddr;
    logic [DW-1:0] pwdata;
    logic          pready = 1'b0;
    logic [DW-1:0] prdata = '0;
    logic          pslverr = 1'b0;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    apb_requester #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_error(rsp_error),
        .psel(psel), .penable(penable), .paddr(paddr), .pwrite(pwrite), .pwdata(pwdata),
        .pready(pready), .prdata(prdata), .pslverr(pslverr)
    );

    typedef struct {
        logic          w;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } req_t;
    typedef struct {
        logic [DW-1:0] r;
        logic          e;
    } rsp_t;

    req_t exp_req[$];
    rsp_t exp_rsp[$];

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Peripheral model: waits = addr[1:0], error when addr[3:0] == 4'hF.
    logic [1:0] wcnt = '0;
    always @(posedge clk) begin
        if (!(psel && penable) || pready) wcnt <= '0;
        else                              wcnt <= wcnt + 2'd1;
    end
    always @(negedge clk) begin
        pready  <= psel && penable && (wcnt == paddr[1:0]);
        prdata  <= {paddr, ~paddr};
        pslverr <= psel && penable && (paddr[3:0] == 4'hF);
    end

    // Monitor / scoreboard
    bit prev_complete = 0;
    bit prev_chain = 0;
    int setup_cnt = 0;
    int acc_cnt = 0;
    always @(negedge clk) begin
        #2;
        if (!rst_n) begin
            prev_complete = 0;
            prev_chain    = 0;
            setup_cnt     = 0;
            acc_cnt       = 0;
        end else begin
            if (prev_complete) begin
                if (prev_chain) check(psel && !penable, "R8 chain to setup", {psel, penable}, 2'b10);
                else            check(!psel, "R9 return to idle", psel, 0);
            end
            if (rsp_done || prev_complete) begin
                check(rsp_done == prev_complete, "R7 done pulse timing", rsp_done, prev_complete);
                if (rsp_done && exp_rsp.size() > 0) begin
                    rsp_t x;
                    x = exp_rsp.pop_front();
                    check(rsp_rdata == x.r, "R7 response data", rsp_rdata, x.r);
                    check(rsp_error == x.e, "R7 response error", rsp_error, x.e);
                end
            end
            prev_complete = 0;
            prev_chain    = 0;
            if (psel && !penable) begin
                setup_cnt++;
                check(!cmd_ready, "R6 not ready in setup", cmd_ready, 0);
            end
            if (penable) check(psel, "R4 enable with select", psel, 1);
            if (psel && penable) begin
                if (acc_cnt == 0) begin
                    check(setup_cnt == 1, "R3 single setup cycle", setup_cnt, 1);
                    setup_cnt = 0;
                end
                acc_cnt++;
                if (!pready) check(!cmd_ready, "R6 not ready in wait", cmd_ready, 0);
                if (pready) begin
                    check(acc_cnt == int'(paddr[1:0]) + 1, "R5 access length", acc_cnt, int'(paddr[1:0]) + 1);
                    if (exp_req.size() == 0) begin
                        check(0, "R2 unexpected transfer", paddr, 0);
                    end else begin
                        req_t q;
                        rsp_t s;
                        q = exp_req.pop_front();
                        check(paddr == q.a && pwrite == q.w, "R2 bus address and direction",
                              {pwrite, paddr}, {q.w, q.a});
                        if (q.w) check(pwdata == q.d, "R2 bus write data", pwdata, q.d);
                        s.r = q.w ? '0 : {q.a, ~q.a};
                        s.e = (q.a[3:0] == 4'hF);
                        exp_rsp.push_back(s);
                    end
                    prev_complete = 1;
                    prev_chain    = cmd_valid && cmd_ready;
                    acc_cnt       = 0;
                end
            end
        end
    end

    task automatic send(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_t r;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_write = w;
        cmd_addr  = a;
        cmd_wdata = d;
        #1;
        while (!cmd_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        r.w = w; r.a = a; r.d = d;
        exp_req.push_back(r);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_wdata = 32'hDEAD_BEEF;
        repeat (n) @(negedge clk);
    endtask

    task automatic run_tests();
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk); #3;
        check(!psel && !penable, "R1 bus idle in reset", {psel, penable}, 0);
        check(!rsp_done, "R1 no done in reset", rsp_done, 0);
        check(cmd_ready, "R1 ready in reset", cmd_ready, 1);
        rst_n = 1'b1;

        // Isolated transfers with idle gaps
        send(1'b1, 16'h1000, 32'h1111_2222);
        idle(3);
        send(1'b0, 16'h2001, 32'h0);
        idle(2);

        // Back-to-back burst with mixed waits
        send(1'b1, 16'h3002, 32'hA5A5_0001);
        send(1'b0, 16'h3003, 32'h0);
        send(1'b1, 16'h3004, 32'hA5A5_0002);
        send(1'b0, 16'h3000, 32'h0);
        idle(4);

        // Error responses on both directions
        send(1'b1, 16'h12AF, 32'hCAFE_F00D);
        send(1'b0, 16'h00CF, 32'h0);
        idle(6);
        send(1'b0, 16'hFFFE, 32'h0);
        idle(6);

        // R10: reset in the middle of a stretched access
        send(1'b0, 16'h0013, 32'h0);
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!(psel && penable)) @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk); #3;
        check(!psel && !penable, "R10 bus dropped by reset", {psel, penable}, 0);
        check(!rsp_done, "R10 no done after reset", rsp_done, 0);
        check(cmd_ready, "R10 ready after reset", cmd_ready, 1);
        exp_req.delete();
        exp_rsp.delete();
        rst_n = 1'b1;
        @(negedge clk); #3;
        check(!rsp_done && !psel, "R10 abandoned transfer silent", {rsp_done, psel}, 0);

        // Traffic resumes after reset
        send(1'b1, 16'h0040, 32'h0BAD_CAFE);
        send(1'b0, 16'h0041, 32'h0);
        idle(8);
        check(exp_req.size() == 0 && exp_rsp.size() == 0, "R7 all responses seen",
              exp_req.size() + exp_rsp.size(), 0);
    endtask

    initial begin
        bit timed_out;
        timed_out = 0;
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) check(0, "watchdog expired", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule